// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Burst Mode

This block produces four pulse-width modulated outputs from one shared period counter. The counter steps from 0 up to a programmable maximum and then wraps. It advances only on a tick strobe from a power-of-two prescaler. Each channel has its own window, set by a start value and a stop value. Each channel also has its own enable and output polarity.

A mode bit chooses between free-running operation and a burst of a programmed number of periods. In burst mode the counter halts at the end of the burst and every output returns to its idle level. A new burst starts only when software raises an enable bit that was low.

All settings are loaded through a small synchronous register write port. A combinational read port returns the register contents.

Top module: `pwm4_unit`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is 4'hF. With polarity 0 an output is active-low, so a disabled channel idles high.
- R2: Register addresses are: 0 control, 1 period maximum, 2 burst length, 4+2*i start of channel i, 5+2*i stop of channel i. The period-maximum register keeps bits 9:0 and reads bits 15:10 as 0. The control register keeps bits 11:0 and reads bits 15:12 as 0.
- R3: While running, the counter advances by one on each tick. When it is at or above the period maximum it wraps to 0 instead. One period therefore lasts maximum+1 ticks.
- R4: Control bits 11:9 hold a select N. A tick occurs once every 2^N system clocks, and N=0 gives a tick on every clock.
- R5: A channel is asserted while the counter value c satisfies start <= c < stop. A stop beyond the maximum asserts the channel up to the end of the period. A start at or above the stop never asserts it.
- R6: Control bits 7:4 are the polarity of channels 3:0. With a 1 the output is high when asserted. With a 0 the output is low when asserted.
- R7: Control bits 3:0 enable channels 3:0. A disabled channel drives the inverse of its polarity bit.
- R8: When control bit 8 is 0 (continuous), the counter repeats periods indefinitely, whatever the burst length.
- R9: When control bit 8 is 1 (burst), the counter stops at the wrap that completes the B-th period, where B is the burst length (B=0 behaves as 1). The counter rests at 0 and every output holds the inverse of its polarity bit.
- R10: A control write that turns any enable bit from 0 to 1 clears the burst state and restarts the counter at 0. A control write that raises no enable bit does not restart a halted burst.
- R11: When a restarting control write lands on the same clock edge as the final wrap of a burst, the restart takes effect and the burst does not halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Contents of the addressed register |
| pwm_out | output | 4 | Channel outputs, bit i is channel i |

## Verification
In burst mode, a restarting control write and the wrap that ends the burst can fall on the same clock edge. The bench provokes this by counting clocks from the start of a 3-period burst of 5-count periods. It places the write of a newly raised enable bit exactly on the fifteenth edge. It then judges the outcome at the channel-0 output. A correct restart shows another full burst of 15 asserted cycles, while a halt that wins the edge would show none.

// File: rtl/pwm4_pkg.sv
// Package: register addresses and helpers shared by the PWM unit.
// Assumes a flat word address space of 16 locations.
package pwm4_pkg;
    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_MAX     = 1;
    localparam int ADDR_BURST   = 2;
    localparam int ADDR_CH_BASE = 4;

    // Address of the start-value register of channel ch.
    function automatic int start_addr(input int ch);
        return ADDR_CH_BASE + 2 * ch;
    endfunction

    // Address of the stop-value register of channel ch.
    function automatic int stop_addr(input int ch);
        return ADDR_CH_BASE + 2 * ch + 1;
    endfunction
endpackage

// File: rtl/pwm4_regs.sv
// Register file of the PWM unit: control, period maximum, burst length and
// per-channel window bounds. It also flags a control write that raises an
// enable bit. Assumes a single-cycle write strobe and a combinational read.
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 10,
    parameter int CYC_W  = 10,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic [NCH-1:0]              en,
    output logic [NCH-1:0]              pol,
    output logic                        oneshot,
    output logic [SEL_W-1:0]            div_sel,
    output logic [CNT_W-1:0]            max_q,
    output logic [CYC_W-1:0]            burst_q,
    output logic [NCH-1:0][CNT_W-1:0]   start_q,
    output logic [NCH-1:0][CNT_W-1:0]   stop_q,
    output logic                        restart
);
    localparam int EN_LSB   = 0;
    localparam int POL_LSB  = NCH;
    localparam int MODE_BIT = 2 * NCH;
    localparam int SEL_LSB  = 2 * NCH + 1;
    localparam int CTRL_W   = SEL_LSB + SEL_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic              wr_ctrl;
    logic [NCH-1:0]    new_en;

    assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign new_en  = reg_wdata[EN_LSB +: NCH];

    // Purpose: hold the control word and decode its fields.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    assign en      = ctrl_q[EN_LSB +: NCH];
    assign pol     = ctrl_q[POL_LSB +: NCH];
    assign oneshot = ctrl_q[MODE_BIT];
    assign div_sel = ctrl_q[SEL_LSB +: SEL_W];

    // Purpose: a control write raising any enable bit restarts the counter.
    assign restart = wr_ctrl && (|(new_en & ~en));

    // Purpose: hold the period maximum and the burst length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q   <= '0;
            burst_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(ADDR_MAX))
                max_q <= reg_wdata[CNT_W-1:0];
            if (reg_addr == ADDR_W'(ADDR_BURST))
                burst_q <= reg_wdata[CYC_W-1:0];
        end
    end

    // Purpose: one start/stop register pair per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[i] <= '0;
                stop_q[i]  <= '0;
            end else if (reg_we) begin
                if (reg_addr == ADDR_W'(start_addr(i)))
                    start_q[i] <= reg_wdata[CNT_W-1:0];
                if (reg_addr == ADDR_W'(stop_addr(i)))
                    stop_q[i] <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    // Purpose: read multiplexer, unused bits return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL))
            reg_rdata = DATA_W'(ctrl_q);
        if (reg_addr == ADDR_W'(ADDR_MAX))
            reg_rdata = DATA_W'(max_q);
        if (reg_addr == ADDR_W'(ADDR_BURST))
            reg_rdata = DATA_W'(burst_q);
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == ADDR_W'(start_addr(i)))
                reg_rdata = DATA_W'(start_q[i]);
            if (reg_addr == ADDR_W'(stop_addr(i)))
                reg_rdata = DATA_W'(stop_q[i]);
        end
    end
endmodule

// File: rtl/pwm4_prescale.sv
// Prescaler: a free-running divider that strobes a tick once every 2^sel
// system clocks. Assumes sel may change at any time; the phase then shifts.
module pwm4_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;

    // Purpose: free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + DIV_W'(1);
    end

    // Purpose: tick when the low sel bits of the divider are all ones.
    assign mask = (DIV_W'(1) << sel) - DIV_W'(1);
    assign tick = ((div_cnt & mask) == mask);
endmodule

// File: rtl/pwm4_timebase.sv
// Shared period counter with period tally and burst halt. Counts 0..max on
// ticks and wraps. In burst mode it halts after the programmed number of
// periods. A restart from the register file has priority over every event.
module pwm4_timebase #(
    parameter int NCH   = 4,
    parameter int CNT_W = 10,
    parameter int CYC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NCH-1:0]   en,
    input  logic             oneshot,
    input  logic             restart,
    input  logic [CNT_W-1:0] max_q,
    input  logic [CYC_W-1:0] burst_q,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             halted
);
    logic [CYC_W-1:0] per_cnt;
    logic [CYC_W:0]   per_next;
    logic             at_top;
    logic             burst_done;

    assign running    = (|en) && !(halted && oneshot);
    assign at_top     = (cnt >= max_q);
    assign per_next   = {1'b0, per_cnt} + (CYC_W+1)'(1);
    assign burst_done = (per_next >= {1'b0, burst_q});

    // Purpose: advance the counter, tally periods and set the halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            per_cnt <= '0;
            halted  <= 1'b0;
        end else if (restart) begin
            cnt     <= '0;
            per_cnt <= '0;
            halted  <= 1'b0;
        end else begin
            if (!oneshot)
                halted <= 1'b0;
            if (!running) begin
                cnt     <= '0;
                per_cnt <= '0;
            end else if (tick) begin
                if (at_top) begin
                    cnt <= '0;
                    if (burst_done) begin
                        per_cnt <= '0;
                        if (oneshot)
                            halted <= 1'b1;
                    end else begin
                        per_cnt <= per_next[CYC_W-1:0];
                    end
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pwm4_chan.sv
// One output channel: compares the shared count with its window and applies
// enable and polarity. Assumes the count and settings are register outputs.
module pwm4_chan #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] start_v,
    input  logic [CNT_W-1:0] stop_v,
    input  logic             en,
    input  logic             pol,
    input  logic             live,
    output logic             out
);
    logic in_win;
    logic active;

    // Purpose: window compare, gated by enable and the live state.
    assign in_win = (cnt >= start_v) && (cnt < stop_v);
    assign active = en && live && in_win;

    // Purpose: apply polarity; an inactive channel shows the inverse level.
    assign out = active ? pol : ~pol;
endmodule

// File: rtl/pwm4_unit.sv
// Top of the four-channel PWM unit: register file, prescaler, shared time
// base and one generated channel per output. Assumes one clock domain and a
// synchronous active-low reset.
module pwm4_unit #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 10,
    parameter int CYC_W  = 10,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [NCH-1:0]            en;
    logic [NCH-1:0]            pol;
    logic                      oneshot;
    logic [SEL_W-1:0]          div_sel;
    logic [CNT_W-1:0]          max_q;
    logic [CYC_W-1:0]          burst_q;
    logic [NCH-1:0][CNT_W-1:0] start_q;
    logic [NCH-1:0][CNT_W-1:0] stop_q;
    logic                      restart;
    logic                      tick;
    logic [CNT_W-1:0]          cnt;
    logic                      running;
    logic                      halted;

    pwm4_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .CYC_W(CYC_W),
        .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en(en), .pol(pol),
        .oneshot(oneshot), .div_sel(div_sel), .max_q(max_q),
        .burst_q(burst_q), .start_q(start_q), .stop_q(stop_q),
        .restart(restart)
    );

    pwm4_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(div_sel), .tick(tick)
    );

    pwm4_timebase #(.NCH(NCH), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .oneshot(oneshot),
        .restart(restart), .max_q(max_q), .burst_q(burst_q), .cnt(cnt),
        .running(running), .halted(halted)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm4_chan #(.CNT_W(CNT_W)) u_ch (
            .cnt(cnt), .start_v(start_q[i]), .stop_v(stop_q[i]),
            .en(en[i]), .pol(pol[i]), .live(running), .out(pwm_out[i])
        );
    end
endmodule

// File: rtl/pwm4_unit_chk.sv
// Checker for the PWM unit, bound to the top module. Watches the counter,
// burst halt and restart against the ports.
module pwm4_unit_chk #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 10,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NCH-1:0]    pwm_out,
    input logic [NCH-1:0]    pol,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  max_q,
    input logic              tick,
    input logic              running,
    input logic              halted,
    input logic              oneshot,
    input logic              restart
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(1)) |-> (reg_rdata[DATA_W-1:CNT_W] == '0));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && (cnt < max_q) && !restart)
        |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_cont_no_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !oneshot |=> !halted);

    p_halt_on_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(tick && oneshot && running && (cnt >= max_q)));

    p_halt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && oneshot) |-> (pwm_out == ~pol) && (cnt == '0));

    p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!halted && (cnt == '0)));
endmodule

bind pwm4_unit pwm4_unit_chk #(
    .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out), .pol(pol), .cnt(cnt), .max_q(max_q), .tick(tick),
    .running(running), .halted(halted), .oneshot(oneshot), .restart(restart)
);

// File: tb/pwm4_unit_bench.sv
// Bench for pwm4_unit: a vector table of channel windows followed by
// directed tests of reset, register map, prescaler, burst and restart.
module pwm4_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pwm4_unit u_pwm4_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic        pol;
        logic [9:0]  mx;
        logic [9:0]  st;
        logic [9:0]  sp;
        logic [10:0] act;
    } vec_t;

    // Channel, polarity, period maximum, start, stop, asserted cycles/period.
    localparam vec_t VEC [6] = '{
        '{2'd0, 1'b1, 10'd9,  10'd2, 10'd5,  11'd3},
        '{2'd1, 1'b1, 10'd9,  10'd0, 10'd10, 11'd10},
        '{2'd2, 1'b0, 10'd9,  10'd5, 10'd5,  11'd0},
        '{2'd3, 1'b0, 10'd15, 10'd4, 10'd20, 11'd12},
        '{2'd0, 1'b1, 10'd7,  10'd6, 10'd3,  11'd0},
        '{2'd1, 1'b1, 10'd0,  10'd0, 10'd1,  11'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 4'(a);
        reg_wdata = 16'(d);
        @(posedge clk);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    // Control word: bits 11:9 prescale, 8 burst mode, 7:4 polarity, 3:0 enable.
    function automatic int ctl(input int mode, input int sel, input int pl,
                               input int en);
        return (sel << 9) | (mode << 8) | (pl << 4) | en;
    endfunction

    // Count samples, one per clock at the falling edge, where channel 0 is high.
    task automatic count_ch0(input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            if (pwm_out[0]) hits++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-R actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d;
        int hits;
        int idle_bad;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 reset pwm_out", int'(pwm_out), 15);
        rd(0, d); check("R1 reset control", d, 0);
        rd(1, d); check("R1 reset maximum", d, 0);

        // R2: register map and reserved bits
        wr(1, 16'hFFFF); rd(1, d); check("R2 maximum reserved bits", d, 16'h03FF);
        wr(8, 16'h0155); rd(8, d); check("R2 channel 2 start", d, 16'h0155);
        wr(0, 16'hFFFF); rd(0, d); check("R2 control reserved bits", d, 16'h0FFF);
        wr(0, 0);

        // R3 R5 R6 R7: vector table, one period per vector, prescale 0
        for (int v = 0; v < 6; v++) begin
            int ch;
            logic [3:0] others;
            ch = int'(VEC[v].ch);
            others = ~(4'b0001 << ch);
            wr(0, 0);
            wr(1, int'(VEC[v].mx));
            wr(4 + 2 * ch, int'(VEC[v].st));
            wr(5 + 2 * ch, int'(VEC[v].sp));
            wr(0, ctl(0, 0, int'(VEC[v].pol) << ch, 1 << ch));
            hits = 0; idle_bad = 0;
            for (int k = 0; k <= int'(VEC[v].mx); k++) begin
                if (pwm_out[ch] == VEC[v].pol) hits++;
                if ((pwm_out & others) != others) idle_bad++;
                @(negedge clk);
            end
            check($sformatf("R5 R6 window vector %0d", v), hits, int'(VEC[v].act));
            check($sformatf("R7 idle channels vector %0d", v), idle_bad, 0);
        end

        // R4: prescale 4, maximum 3, channel 0 window [0,1): 4 of 16 clocks
        wr(0, 0); wr(1, 3); wr(4, 0); wr(5, 1);
        wr(0, ctl(0, 2, 1, 1));
        count_ch0(16, hits);
        check("R4 prescale by 4", hits, 4);

        // R9: burst of 3 periods of 5 counts, channel 0 always asserted
        wr(0, 0); wr(1, 4); wr(2, 3); wr(4, 0); wr(5, 5);
        wr(0, ctl(1, 0, 1, 1));
        count_ch0(40, hits);
        check("R9 burst length 3", hits, 15);
        check("R9 halted outputs idle", int'(pwm_out), 4'b1110);

        // R10: rewrite with no enable rising does not restart
        wr(0, ctl(1, 0, 1, 1));
        count_ch0(20, hits);
        check("R10 no restart without rising enable", hits, 0);

        // R10: enable dropped and raised restarts a full burst
        wr(0, ctl(1, 0, 1, 0));
        wr(0, ctl(1, 0, 1, 1));
        count_ch0(40, hits);
        check("R10 restart on rising enable", hits, 15);

        // R9: burst length 0 behaves as one period
        wr(0, ctl(1, 0, 1, 0)); wr(2, 0);
        wr(0, ctl(1, 0, 1, 1));
        count_ch0(20, hits);
        check("R9 burst length 0", hits, 5);

        // R11: restart write on the same edge as the final wrap
        wr(0, ctl(1, 0, 1, 0)); wr(2, 3);
        wr(0, ctl(1, 0, 1, 1));
        repeat (13) @(negedge clk);
        wr(0, ctl(1, 0, 1, 3));
        count_ch0(40, hits);
        check("R11 restart wins over final wrap", hits, 15);

        // R8: continuous mode keeps repeating past the burst length
        wr(0, 0); wr(2, 3); wr(5, 2);
        wr(0, ctl(0, 0, 1, 1));
        count_ch0(60, hits);
        check("R8 continuous repeats", hits, 24);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule